// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block models a single-port synchronous memory whose read and write pipelines have been given the same data latency, so a bus master can issue reads and writes in any mix on consecutive clocks with no idle cycle between them. Control and address are sampled on one rising edge (the address edge). For a read, the word is loaded into an output register on the next enabled edge. For a write, the data and the byte-lane enables are sampled one enabled edge later again, two edges after the address. On every enabled edge the pipeline shifts by one stage, so a new operation can be accepted while an earlier one is still in its data phase.

The shared data bus is split into a write-data input, a read-data output and an active-high drive flag. The drive flag stands in for the output buffers. The memory array sits inside the block, with one array per byte lane. Each lane is 9 bits wide: 8 data bits plus one parity bit.

An active-low clock enable freezes the whole block when it is high. An asynchronous output-enable input gates the drive flag.

Top module: `nt_sram`

## Requirements
- R1: An operation is accepted at an edge only when clk_en_n=0, sel_a_n=0, sel_b=1, sel_c_n=0 and load_n=0. wr_n=0 makes it a write and wr_n=1 makes it a read. Any other combination accepts nothing and changes no memory word.
- R2: After a read is accepted, the addressed word appears on rdata after the next enabled edge, and rdata_drive is 1 during that cycle while out_en_n is 0.
- R3: rdata_drive follows out_en_n combinationally. It is never 1 while out_en_n is 1, and it returns to 1 without any clock edge when out_en_n falls during a valid read cycle.
- R4: After an accepted write, rdata_drive is 0 in the cycle that follows the next enabled edge, whatever out_en_n is. wdata and lane_wr_n are sampled at the second enabled edge after the address edge. Values on them at other edges are ignored.
- R5: lane_wr_n[i]=0 updates lane i of the addressed word, and lane i is wdata[9*i+8:9*i]. Lanes whose enable is 1 keep their stored value.
- R6: A cycle that accepts no operation is pipelined like a read. rdata_drive is 0 after the following enabled edge.
- R7: Reads and writes to different addresses can alternate on every clock with no idle cycle, and each read returns the correct stored word.
- R8: A read accepted on the edge right after a write to the same address returns the newly written lanes merged with the old contents of the lanes that were not written.
- R9: While clk_en_n=1 an edge changes nothing. rdata, rdata_drive (for a fixed out_en_n), the pipeline stages and the memory all hold.
- R10: Reset (rst_n=0, asynchronous) clears the pipeline valid flags, so rdata_drive is 0. The memory contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline flags |
| clk_en_n | input | 1 | Active-low clock enable; high freezes all state |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | 0 = write, 1 = read, sampled at the address edge |
| load_n | input | 1 | Active-low load of a new address and operation |
| lane_wr_n | input | LANES | Per-lane write enables, active low, sampled with the write data |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data, 9 bits per lane |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| rdata | output | DATA_W | Output register contents |
| rdata_drive | output | 1 | 1 when the block would drive the bus |

## Verification
The bench goes after these cases:

- Back-to-back turnarounds. A design whose write data lands one edge early or late would store the junk the bench drives on wdata in the other cycles.
- A read of the address written on the edge just before it. Without forwarding, that read returns the stale word.
- Partial lane masks, including one followed at once by a read. A wrong mask or lane order corrupts lanes that should have been kept.
- Chip-select and load combinations that must accept nothing. A loose decode would write the memory or drive the bus.
- Clock-enable stalls placed inside a write's data phase. A design that shifts on a held edge would sample the junk there.
- A mid-cycle toggle of out_en_n. This exposes a registered output enable.
- A reset in the middle of the run. This must drop the drive flag but keep the memory.

// File: rtl/nt_sram_pkg.sv
package nt_sram_pkg;

   localparam int LANE_DATA_W = 8;
   localparam int LANE_W      = LANE_DATA_W + 1;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;

   function automatic op_e decode_op(input logic sel_a_n, input logic sel_b,
                                     input logic sel_c_n, input logic load_n,
                                     input logic wr_n);
      logic selected;
      selected = !sel_a_n && sel_b && !sel_c_n && !load_n;
      if (!selected)
         return OP_IDLE;
      return wr_n ? OP_READ : OP_WRITE;
   endfunction

endpackage

// File: rtl/nt_sram_ctrl.sv
module nt_sram_ctrl
   import nt_sram_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  op_e               req_op,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rd_go,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              wr_go,
   output logic [ADDR_W-1:0] wr_addr,
   output logic              rd_valid
);

   typedef struct packed {
      op_e               op;
      logic [ADDR_W-1:0] addr;
   } stage_t;

   stage_t s1_q;
   stage_t s2_q;

   // s1: operation accepted at the address edge
   // s2: same operation one enabled edge later (write data phase)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_q     <= '0;
         s2_q     <= '0;
         rd_valid <= 1'b0;
      end else if (step) begin
         s1_q     <= '{op: req_op, addr: req_addr};
         s2_q     <= s1_q;
         rd_valid <= (s1_q.op == OP_READ);
      end
   end

   assign rd_go   = step && (s1_q.op == OP_READ);
   assign rd_addr = s1_q.addr;
   assign wr_go   = step && (s2_q.op == OP_WRITE);
   assign wr_addr = s2_q.addr;

endmodule

// File: rtl/nt_sram_lane.sv
module nt_sram_lane
   import nt_sram_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_go,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              wr_go,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              lane_en,
   input  logic [LANE_W-1:0] lane_wdata,
   output logic [LANE_W-1:0] rd_q
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [LANE_W-1:0] mem [DEPTH];
   logic              lane_wr;
   logic              fwd_hit;

   assign lane_wr = wr_go && lane_en;
   assign fwd_hit = lane_wr && (wr_addr == rd_addr);

   always_ff @(posedge clk) begin
      if (lane_wr)
         mem[wr_addr] <= lane_wdata;
   end

   // the read register takes the word being written on this same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_q <= '0;
      else if (rd_go)
         rd_q <= fwd_hit ? lane_wdata : mem[rd_addr];
   end

endmodule

// File: rtl/nt_sram.sv
module nt_sram
   import nt_sram_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int ADDR_W = 6,
   parameter int DATA_W = LANES * nt_sram_pkg::LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en_n,
   input  logic              sel_a_n,
   input  logic              sel_b,
   input  logic              sel_c_n,
   input  logic              wr_n,
   input  logic              load_n,
   input  logic [LANES-1:0]  lane_wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              out_en_n,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_drive
);

   if (LANES < 1) begin : g_bad_lanes
      $error("nt_sram: LANES must be at least 1");
   end
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
      $error("nt_sram: ADDR_W must be in 1..16");
   end
   if (DATA_W != LANES * LANE_W) begin : g_bad_width
      $error("nt_sram: DATA_W must equal LANES * 9");
   end

   logic              step;
   op_e               req_op;
   logic              rd_go;
   logic              wr_go;
   logic              rd_valid;
   logic [ADDR_W-1:0] rd_addr;
   logic [ADDR_W-1:0] wr_addr;

   assign step   = !clk_en_n;
   assign req_op = decode_op(sel_a_n, sel_b, sel_c_n, load_n, wr_n);

   nt_sram_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .req_op   (req_op),
      .req_addr (addr),
      .rd_go    (rd_go),
      .rd_addr  (rd_addr),
      .wr_go    (wr_go),
      .wr_addr  (wr_addr),
      .rd_valid (rd_valid)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      nt_sram_lane #(.ADDR_W(ADDR_W)) lane_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .rd_go      (rd_go),
         .rd_addr    (rd_addr),
         .wr_go      (wr_go),
         .wr_addr    (wr_addr),
         .lane_en    (!lane_wr_n[g]),
         .lane_wdata (wdata[g*LANE_W +: LANE_W]),
         .rd_q       (rdata[g*LANE_W +: LANE_W])
      );
   end

   // a write or idle stage leaves rd_valid low, so the data phase never drives
   assign rdata_drive = rd_valid && !out_en_n;

endmodule

// File: rtl/nt_sram_chk.sv
module nt_sram_chk #(
   parameter int LANES  = 4,
   parameter int ADDR_W = 6,
   parameter int DATA_W = LANES * 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clk_en_n,
   input logic              sel_a_n,
   input logic              sel_b,
   input logic              sel_c_n,
   input logic              wr_n,
   input logic              load_n,
   input logic [LANES-1:0]  lane_wr_n,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic              out_en_n,
   input logic [DATA_W-1:0] rdata,
   input logic              rdata_drive
);

   logic took;
   logic m1_rd;
   logic m1_wr;

   assign took = !sel_a_n && sel_b && !sel_c_n && !load_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m1_rd <= 1'b0;
         m1_wr <= 1'b0;
      end else if (!clk_en_n) begin
         m1_rd <= took && wr_n;
         m1_wr <= took && !wr_n;
      end
   end

   // R9
   hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_n |=> $stable(rdata));

   // R3
   oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_drive |-> !out_en_n);

   // R4
   wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && m1_wr) |=> !rdata_drive);

   // R6
   desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !m1_rd && !m1_wr) |=> !rdata_drive);

   // R2
   rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && m1_rd) |=> (rdata_drive == !out_en_n));

   // R10
   rst_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> !rdata_drive);

endmodule

bind nt_sram nt_sram_chk #(.LANES(LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/nt_sram_tb_top.sv
module nt_sram_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int LANES  = 4;
   localparam int ADDR_W = 6;
   localparam int DW     = LANES * 9;
   localparam int DEPTH  = 1 << ADDR_W;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              clk_en_n;
   logic              sel_a_n;
   logic              sel_b;
   logic              sel_c_n;
   logic              wr_n;
   logic              load_n;
   logic [LANES-1:0]  lane_wr_n;
   logic [ADDR_W-1:0] addr;
   logic [DW-1:0]     wdata;
   logic              out_en_n;
   logic [DW-1:0]     rdata;
   logic              rdata_drive;

   nt_sram #(.LANES(LANES), .ADDR_W(ADDR_W)) dut_i (
      .clk, .rst_n, .clk_en_n, .sel_a_n, .sel_b, .sel_c_n, .wr_n, .load_n,
      .lane_wr_n, .addr, .wdata, .out_en_n, .rdata, .rdata_drive
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      bit             wr;
      bit             rd;
      int             a;
      logic [DW-1:0]  d;
      logic [LANES-1:0] bwn;
   } bop_t;

   typedef struct {
      bit            v;
      logic [DW-1:0] d;
      string         tag;
   } exp_t;

   int            errors = 0;
   int            checks = 0;
   bit            done = 0;
   exp_t          sb[$];
   bop_t          b1, b2;
   logic [DW-1:0] ref_mem [DEPTH];
   bit            last_v;
   logic [DW-1:0] last_d;

   function automatic logic [DW-1:0] pat(input int i);
      logic [63:0] x;
      x = 64'(i + 1) * 64'h9E3779B97F4A7C15;
      return x[5 +: DW];
   endfunction

   task automatic check_bit(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic clear_model();
      b1     = '{wr: 0, rd: 0, a: 0, d: '0, bwn: '0};
      b2     = b1;
      last_v = 0;
      last_d = '0;
   endtask

   // driver: applies one cycle of stimulus and pushes the expected output
   task automatic step(input bit en, input bit [2:0] sels, input bit ld,
                       input bit wr, input int a, input logic [DW-1:0] d,
                       input logic [LANES-1:0] bwn, input bit oe, input string tag);
      bit acc;
      @(negedge clk);
      clk_en_n = !en;
      sel_a_n  = !sels[0];
      sel_b    = sels[1];
      sel_c_n  = !sels[2];
      load_n   = !ld;
      wr_n     = !wr;
      addr     = a[ADDR_W-1:0];
      out_en_n = !oe;
      if (en && b2.wr) begin
         wdata     = b2.d;
         lane_wr_n = b2.bwn;
      end else begin
         wdata     = ~pat(a + 77);
         lane_wr_n = '0;
      end
      if (en) begin
         if (b2.wr)
            for (int l = 0; l < LANES; l++)
               if (!b2.bwn[l]) ref_mem[b2.a][l*9 +: 9] = b2.d[l*9 +: 9];
         if (b1.rd) last_d = ref_mem[b1.a];
         last_v = b1.rd;
         acc = (sels == 3'b111) && ld;
         b2 = b1;
         b1 = '{wr: acc && wr, rd: acc && !wr, a: a, d: d, bwn: bwn};
      end
      sb.push_back('{v: last_v, d: last_d, tag: tag});
   endtask

   task automatic wr_op(input int a, input logic [DW-1:0] d,
                        input logic [LANES-1:0] bwn, input string tag);
      step(1, 3'b111, 1, 1, a, d, bwn, 1, tag);
   endtask

   task automatic rd_op(input int a, input string tag);
      step(1, 3'b111, 1, 0, a, '0, '0, 1, tag);
   endtask

   task automatic idle(input string tag);
      step(1, 3'b000, 1, 0, 0, '0, '0, 1, tag);
   endtask

   task automatic hold(input string tag);
      step(0, 3'b111, 1, 0, 0, '0, '0, 1, tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      clk_en_n = 0; sel_a_n = 1; sel_b = 0; sel_c_n = 1; load_n = 1; wr_n = 1;
      sb.delete();
      clear_model();
      repeat (2) @(negedge clk);
      check_bit("R10 drive low in reset", rdata_drive, 1'b0);
      rst_n = 1;
   endtask

   // monitor: pops one expected item per clock that the driver issued
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            exp_t e;
            logic ed;
            e  = sb.pop_front();
            ed = e.v && !out_en_n;
            checks++;
            if (rdata_drive !== ed) begin
               errors++;
               $display("FAIL %s drive: actual=%0b expected=%0b", e.tag, rdata_drive, ed);
            end else if (e.v && rdata !== e.d) begin
               errors++;
               $display("FAIL %s data: actual=%h expected=%h", e.tag, rdata, e.d);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rst_n = 0; clk_en_n = 0; sel_a_n = 1; sel_b = 0; sel_c_n = 1;
      wr_n = 1; load_n = 1; lane_wr_n = '1; addr = '0; wdata = '0; out_en_n = 1;
      clear_model();
      do_reset();

      // R4 fill with back-to-back full writes
      for (int i = 0; i < 16; i++) wr_op(i, pat(i), '0, "R4");
      idle("R4"); idle("R4");

      // R2 read back
      for (int i = 0; i < 16; i++) rd_op(i, "R2");
      idle("R2"); idle("R2");

      // R7 alternating reads and writes with no gap
      rd_op(0, "R7"); wr_op(20, pat(20), '0, "R7");
      rd_op(1, "R7"); wr_op(21, pat(21), '0, "R7");
      rd_op(20, "R7"); rd_op(21, "R7");
      wr_op(2, pat(22), '0, "R7"); rd_op(3, "R7"); wr_op(4, pat(23), '0, "R7");
      rd_op(2, "R7"); rd_op(4, "R7");
      idle("R7"); idle("R7");

      // R8 read right after write to the same word, full and partial
      wr_op(12, pat(30), '0, "R8"); rd_op(12, "R8");
      wr_op(12, pat(31), 4'b0101, "R8"); rd_op(12, "R8");
      idle("R8"); idle("R8");

      // R5 partial lane writes
      wr_op(5, pat(32), 4'b1010, "R5"); idle("R5"); idle("R5");
      rd_op(5, "R5");
      wr_op(6, pat(33), 4'b1110, "R5"); idle("R5"); idle("R5");
      rd_op(6, "R5"); idle("R5"); idle("R5");

      // R1 decode: each incomplete combination accepts nothing
      step(1, 3'b110, 1, 1, 0, pat(40), '0, 1, "R1");
      step(1, 3'b101, 1, 1, 0, pat(41), '0, 1, "R1");
      step(1, 3'b011, 1, 1, 0, pat(42), '0, 1, "R1");
      step(1, 3'b111, 0, 1, 0, pat(43), '0, 1, "R1");
      idle("R1"); idle("R1");
      rd_op(0, "R1"); idle("R1"); idle("R1");

      // R6 deselect after read; blocked read does not drive
      rd_op(1, "R6");
      step(1, 3'b011, 1, 0, 1, '0, '0, 1, "R6");
      rd_op(7, "R6");
      step(1, 3'b111, 0, 0, 7, '0, '0, 1, "R6");
      idle("R6");

      // R9 stalls inside a write data phase and after a read
      wr_op(3, pat(50), '0, "R9");
      hold("R9"); hold("R9"); hold("R9");
      idle("R9");
      hold("R9");
      idle("R9");
      rd_op(3, "R9");
      hold("R9"); hold("R9");
      idle("R9"); idle("R9");

      // R3 asynchronous output enable
      rd_op(4, "R3");
      step(0, 3'b000, 1, 0, 0, '0, '0, 1, "R3");
      step(0, 3'b000, 1, 0, 0, '0, '0, 0, "R3");
      step(1, 3'b000, 1, 0, 0, '0, '0, 1, "R3");
      @(posedge clk); #3;
      out_en_n = 1;
      #1 check_bit("R3 drive drops with out_en_n", rdata_drive, 1'b0);
      out_en_n = 0;
      #1 check_bit("R3 drive returns with out_en_n", rdata_drive, 1'b1);
      idle("R3"); idle("R3");

      // R10 memory survives reset
      do_reset();
      rd_op(0, "R10"); rd_op(5, "R10"); rd_op(12, "R10");
      idle("R10"); idle("R10");

      repeat (3) @(posedge clk);
      #2;
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule